// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

The block is a bank of three 16-bit down-counting timer channels behind one small register port. A processor configures a channel by writing a control byte to the shared control address. The byte picks the channel, how its count is moved over the 8-bit bus (low byte only, high byte only, low then high, or a snapshot command), a three-bit mode code and the count format (plain binary or four BCD decades). The processor then writes the count through the channel's own data address and can read the running or snapshotted count back the same way.

Each channel has its own count clock input. A newly written count does not reach the counting register straight away. It waits until the count clock has risen and then fallen. After that, the channel decrements on every falling count-clock edge. In mode 0 the channel output works as a terminal-count flag. It drops when the channel is configured or given a new count, and it rises when the count steps to zero. The other mode codes are stored, and for them the output simply rests high. The count clocks must be synchronous to the system clock and must stay at each level for at least one system clock.

Top module: `tri_interval_timer`

## Requirements
- R1: Address 3 is the control address. Addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2. A read of address 3 returns 0x00.
- R2: In the control byte, bits [7:6] select the channel (00, 01, 10). A control byte with bits [7:6] = 11 is ignored: no channel output, setting or count changes.
- R3: Control bits [5:4] set the byte access order. 10 means the low byte only, and a write clears the high byte. 01 means the high byte only, and a write clears the low byte. 11 means the low byte, then the high byte. Reads follow the same order.
- R4: Control bits [3:1] are the mode code and bit 3 is a don't-care for codes x10 and x11. Writing a control byte with mode 000 drives that channel's output low. Any other mode drives it high.
- R5: Control bit 0 selects the count format: 0 is 16-bit binary and 1 is four BCD decades with a decade borrow. Stepping down from 0 gives 0xFFFF in binary format and 0x9999 in BCD format.
- R6: A completed count write reaches the counting register only on a falling count-clock edge that follows a rising edge seen after the write. Until then, reads return the old count. The count changes only on falling count-clock edges.
- R7: In mode 0 the output goes high when a decrement makes the count zero. It stays high while counting continues past zero, and it returns low when a new count is completed.
- R8: In mode 0 with two-byte access, writing the low byte stops the count. Writing the high byte then starts the new count after the R6 load.
- R9: Control bits [5:4] = 00 snapshot the selected count. Reads return the snapshot in the programmed byte order until all its bytes are read, then live reads resume. A second snapshot command before the first has been read out is ignored.
- R10: Each channel has its own write and read byte pointers. A control byte resets that channel's pointers to the low byte.
- R11: After reset every count is 0, every output is low, and every channel uses two-byte access in mode 0 binary format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 2 | Register address (0-2 channel data, 3 control) |
| wdata | input | 8 | Write data byte |
| wr_stb | input | 1 | Write strobe, one cycle per byte |
| rd_stb | input | 1 | Read strobe, advances the read byte pointer |
| rdata | output | 8 | Read data for the current address (combinational) |
| cnt_clk | input | 3 | Count clock per channel, synchronous to clk |
| tout | output | 3 | Channel outputs |

## Verification
On every cycle, the assertions check these local rules: the output level after a control byte, that the count moves only on a count-clock fall, that the output rises on the step to zero, that writing the low byte halts the count, that a snapshot is held until it is read, and that at most one decode target fires per access. What only the bench scenarios can show is the full sequences: the delayed load after a rise and fall, the byte ordering of reads and writes, the binary and BCD wrap values, snapshot read-out followed by live reads, pointer reset by a repeated control byte, and a rejected illegal control byte leaving every channel untouched.

// File: rtl/pit_pkg.sv
// Package: shared types and field codes for the interval timer.
// Assumes: 8-bit bus, control byte layout {sel[1:0], acc[1:0], mode[2:0], fmt}.
package pit_pkg;

    localparam logic [1:0] ACC_SNAP = 2'b00;
    localparam logic [1:0] ACC_HI   = 2'b01;
    localparam logic [1:0] ACC_LO   = 2'b10;
    localparam logic [1:0] ACC_BOTH = 2'b11;

    localparam logic [1:0] CTRL_ADDR = 2'b11;

    typedef struct packed {
        logic [1:0] acc;    // byte access order
        logic [2:0] mode;   // mode code
        logic       bcd;    // 1 = four BCD decades
    } chan_cfg_t;

endpackage

// File: rtl/pit_ctrl_decode.sv
// Module: pit_ctrl_decode
// Splits one bus access into per-channel events: a new setting, a
// snapshot command, a data write or a data read.
// Assumes: at most one strobe per cycle; channel select 11 is illegal.
module pit_ctrl_decode
    import pit_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic [1:0]        addr,
    input  logic [7:0]        wdata,
    input  logic              wr_stb,
    input  logic              rd_stb,
    output chan_cfg_t         cfg,
    output logic [NUM_CH-1:0] cfg_load,
    output logic [NUM_CH-1:0] snap_cmd,
    output logic [NUM_CH-1:0] data_wr,
    output logic [NUM_CH-1:0] data_rd
);

    logic ctrl_wr;

    // Control-address write detection.
    assign ctrl_wr = wr_stb && (addr == CTRL_ADDR);

    // Setting fields taken straight from the control byte.
    assign cfg = '{acc: wdata[5:4], mode: wdata[3:1], bcd: wdata[0]};

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
            localparam logic [1:0] SEL = 2'(g);
            // Per-channel event decode.
            assign cfg_load[g] = ctrl_wr && (wdata[7:6] == SEL) && (wdata[5:4] != ACC_SNAP);
            assign snap_cmd[g] = ctrl_wr && (wdata[7:6] == SEL) && (wdata[5:4] == ACC_SNAP);
            assign data_wr[g]  = wr_stb && (addr == SEL);
            assign data_rd[g]  = rd_stb && (addr == SEL);
        end
    endgenerate

    // Immediate checks on decode exclusivity and illegal select.
    always_comb begin
        if (wr_stb || rd_stb) begin
            a_r1_one_target: assert ($onehot0({cfg_load, snap_cmd, data_wr, data_rd}))
                else $error("decode hit more than one target");
        end
        if (ctrl_wr && (wdata[7:6] == 2'b11)) begin
            a_r2_illegal_select: assert (cfg_load == '0 && snap_cmd == '0)
                else $error("illegal select reached a channel");
        end
    end

endmodule

// File: rtl/pit_count_dec.sv
// Module: pit_count_dec
// Combinational one-step decrement in binary or packed BCD.
// Assumes: CW is a multiple of 4; BCD input digits are 0..9.
module pit_count_dec #(
    parameter int CW = 16
) (
    input  logic [CW-1:0] val,
    input  logic          bcd,
    output logic [CW-1:0] nxt
);

    localparam int DIGITS = CW / 4;

    logic [DIGITS:0]  brw;
    logic [CW-1:0]    bcd_nxt;

    assign brw[0] = 1'b1;

    generate
        for (genvar g = 0; g < DIGITS; g++) begin : g_dig
            logic [3:0] nib;
            // Decade step with borrow from the next lower digit.
            assign nib = val[4*g +: 4];
            assign bcd_nxt[4*g +: 4] = !brw[g] ? nib : ((nib == 4'd0) ? 4'd9 : nib - 4'd1);
            assign brw[g+1] = brw[g] && (nib == 4'd0);
        end
    endgenerate

    // Format select.
    assign nxt = bcd ? bcd_nxt : (val - CW'(1));

endmodule

// File: rtl/pit_channel.sv
// Module: pit_channel
// One counter channel: holding register, delayed load, decrement on count
// clock falls, snapshot latch, byte pointers and the mode 0 output.
// Assumes: cnt_clk is synchronous to clk and stays at each level for at
// least one clk cycle; CW is 16 (two bus bytes).
module pit_channel
    import pit_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cnt_clk,
    input  chan_cfg_t  cfg_in,
    input  logic       cfg_load,
    input  logic       snap_cmd,
    input  logic       data_wr,
    input  logic       data_rd,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       out
);

    localparam int HB = CW / 2;

    chan_cfg_t      cfg;
    logic           cc_q;
    logic           cc_rise;
    logic           cc_fall;
    logic [CW-1:0]  hold;
    logic [CW-1:0]  ce;
    logic [CW-1:0]  ce_nxt;
    logic [CW-1:0]  snap;
    logic           snapped;
    logic           pend;
    logic           armed;
    logic           running;
    logic           wr_hi;
    logic           rd_hi;
    logic           mode0;
    logic           do_load;
    logic [CW-1:0]  rd_src;

    // Count clock edge detection against the previous sample.
    assign cc_rise = cnt_clk && !cc_q;
    assign cc_fall = !cnt_clk && cc_q;
    assign mode0   = (cfg.mode == 3'b000);
    assign do_load = cc_fall && pend && armed;

    pit_count_dec #(.CW(CW)) i_dec (
        .val (ce),
        .bcd (cfg.bcd),
        .nxt (ce_nxt)
    );

    // Channel state update: setting, writes, reads, snapshot and counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg     <= '{acc: ACC_BOTH, mode: 3'b000, bcd: 1'b0};
            cc_q    <= 1'b0;
            hold    <= '0;
            ce      <= '0;
            snap    <= '0;
            snapped <= 1'b0;
            pend    <= 1'b0;
            armed   <= 1'b0;
            running <= 1'b0;
            wr_hi   <= 1'b0;
            rd_hi   <= 1'b0;
            out     <= 1'b0;
        end else begin
            cc_q <= cnt_clk;
            if (cfg_load) begin
                cfg     <= cfg_in;
                wr_hi   <= 1'b0;
                rd_hi   <= 1'b0;
                snapped <= 1'b0;
                pend    <= 1'b0;
                armed   <= 1'b0;
                running <= 1'b0;
                out     <= (cfg_in.mode != 3'b000);
            end else begin
                // Count clock: arm after a rise, load or step on a fall.
                if (cc_rise && pend) begin
                    armed <= 1'b1;
                end
                if (do_load) begin
                    ce      <= hold;
                    running <= 1'b1;
                    pend    <= 1'b0;
                    armed   <= 1'b0;
                end else if (cc_fall && running) begin
                    ce <= ce_nxt;
                    if (mode0 && (ce_nxt == '0)) begin
                        out <= 1'b1;
                    end
                end
                // Snapshot command, ignored while one is pending read-out.
                if (snap_cmd && !snapped) begin
                    snap    <= ce;
                    snapped <= 1'b1;
                end
                // Read pointer advance and snapshot release.
                if (data_rd) begin
                    if ((cfg.acc == ACC_BOTH) && !rd_hi) begin
                        rd_hi <= 1'b1;
                    end else begin
                        rd_hi   <= 1'b0;
                        snapped <= 1'b0;
                    end
                end
                // Count byte writes; a write overrides the count clock arm.
                if (data_wr) begin
                    unique case (cfg.acc)
                        ACC_HI: begin
                            hold  <= {wdata, {HB{1'b0}}};
                            pend  <= 1'b1;
                            armed <= 1'b0;
                            if (mode0) out <= 1'b0;
                        end
                        ACC_LO: begin
                            hold  <= {{HB{1'b0}}, wdata};
                            pend  <= 1'b1;
                            armed <= 1'b0;
                            if (mode0) out <= 1'b0;
                        end
                        ACC_BOTH: begin
                            if (!wr_hi) begin
                                hold[HB-1:0] <= wdata;
                                wr_hi        <= 1'b1;
                                pend         <= 1'b0;
                                armed        <= 1'b0;
                                if (mode0) running <= 1'b0;
                            end else begin
                                hold[CW-1:HB] <= wdata;
                                wr_hi         <= 1'b0;
                                pend          <= 1'b1;
                                armed         <= 1'b0;
                                if (mode0) out <= 1'b0;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // Read byte selection from snapshot or live count.
    always_comb begin
        rd_src = snapped ? snap : ce;
        if ((cfg.acc == ACC_HI) || ((cfg.acc == ACC_BOTH) && rd_hi)) begin
            rdata = rd_src[CW-1:HB];
        end else begin
            rdata = rd_src[HB-1:0];
        end
    end

    // Output level right after a new setting.
    a_r4_mode0_low: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load && (cfg_in.mode == 3'b000) |=> !out);
    a_r4_other_high: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load && (cfg_in.mode != 3'b000) |=> out);

    // Count register moves only on a count clock fall.
    a_r6_step_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !cc_fall |=> $stable(ce));

    // Step to zero in mode 0 raises the output.
    a_r7_tc_high: assert property (@(posedge clk) disable iff (!rst_n)
        cc_fall && running && !do_load && mode0 && (ce == CW'(1)) && !cfg_load && !data_wr
        |=> out);

    // Low byte of a two-byte write halts the count.
    a_r8_low_byte_halts: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr && !cfg_load && (cfg.acc == ACC_BOTH) && !wr_hi && mode0 |=> !running);

    // Snapshot survives until read out or a new setting.
    a_r9_snap_held: assert property (@(posedge clk) disable iff (!rst_n)
        snapped && !data_rd && !cfg_load |=> snapped && $stable(snap));

endmodule

// File: rtl/tri_interval_timer.sv
// Module: tri_interval_timer
// Top of the interval timer: one decode block feeding NUM_CH channels,
// plus the read data mux.
// Assumes: NUM_CH <= 3 so every channel has its own data address.
module tri_interval_timer
    import pit_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CW     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr,
    input  logic [7:0]        wdata,
    input  logic              wr_stb,
    input  logic              rd_stb,
    output logic [7:0]        rdata,
    input  logic [NUM_CH-1:0] cnt_clk,
    output logic [NUM_CH-1:0] tout
);

    chan_cfg_t         cfg;
    logic [NUM_CH-1:0] cfg_load;
    logic [NUM_CH-1:0] snap_cmd;
    logic [NUM_CH-1:0] data_wr;
    logic [NUM_CH-1:0] data_rd;
    logic [7:0]        ch_rdata [NUM_CH];

    pit_ctrl_decode #(.NUM_CH(NUM_CH)) i_dec (
        .addr     (addr),
        .wdata    (wdata),
        .wr_stb   (wr_stb),
        .rd_stb   (rd_stb),
        .cfg      (cfg),
        .cfg_load (cfg_load),
        .snap_cmd (snap_cmd),
        .data_wr  (data_wr),
        .data_rd  (data_rd)
    );

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            pit_channel #(.CW(CW)) i_ch (
                .clk      (clk),
                .rst_n    (rst_n),
                .cnt_clk  (cnt_clk[g]),
                .cfg_in   (cfg),
                .cfg_load (cfg_load[g]),
                .snap_cmd (snap_cmd[g]),
                .data_wr  (data_wr[g]),
                .data_rd  (data_rd[g]),
                .wdata    (wdata),
                .rdata    (ch_rdata[g]),
                .out      (tout[g])
            );
        end
    endgenerate

    // Read mux; the control address reads as zero.
    always_comb begin
        rdata = 8'h00;
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == 2'(i)) rdata = ch_rdata[i];
        end
    end

endmodule

// File: tb/test_tri_interval_timer.sv
module test_tri_interval_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic       wr_stb = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] rdata;
    logic [2:0] cnt_clk = 3'b000;
    logic [2:0] tout;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #4 clk = ~clk;

    tri_interval_timer i_tri_interval_timer (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .rdata(rdata),
        .cnt_clk(cnt_clk), .tout(tout)
    );

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    // Driver: issue a read strobe and queue the expected byte.
    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        addr = a; rd_stb = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic tick(input int ch);
        @(negedge clk);
        cnt_clk[ch] = 1'b1;
        repeat (2) @(negedge clk);
        cnt_clk[ch] = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic chk_out(input int ch, input logic e, input string tag);
        @(negedge clk);
        #1;
        total++;
        if (tout[ch] !== e) begin
            bad++;
            $display("FAIL %s: tout[%0d] actual=%b expected=%b", tag, ch, tout[ch], e);
        end
    endtask

    // Monitor: pop and compare on each read strobe.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rd_stb && exp_q.size() > 0) begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if (rdata !== e) begin
                    bad++;
                    $display("FAIL %s: rdata actual=%h expected=%h", t, rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [2:0] saved;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        rd(2'd0, 8'h00, "R11 reset lo");
        rd(2'd0, 8'h00, "R11 reset hi");
        chk_out(0, 1'b0, "R11 reset out");
        // R1 control address reads zero
        rd(2'd3, 8'h00, "R1 ctrl read");

        // Channel 0: two-byte, mode 0, binary
        wr(2'd3, 8'h30);
        chk_out(0, 1'b0, "R4 mode0 low");
        wr(2'd0, 8'h05);
        wr(2'd0, 8'h00);
        rd(2'd0, 8'h00, "R6 before load lo");
        rd(2'd0, 8'h00, "R6 before load hi");
        tick(0);
        rd(2'd0, 8'h05, "R6 loaded lo");
        rd(2'd0, 8'h00, "R6 loaded hi");
        for (int i = 0; i < 4; i++) tick(0);
        chk_out(0, 1'b0, "R7 before tc");
        tick(0);
        chk_out(0, 1'b1, "R7 at tc");
        tick(0);
        chk_out(0, 1'b1, "R7 sticky");
        rd(2'd0, 8'hFF, "R5 bin wrap lo");
        rd(2'd0, 8'hFF, "R5 bin wrap hi");

        // R8 halt on low byte, restart on high byte
        wr(2'd0, 8'h03);
        tick(0);
        rd(2'd0, 8'hFF, "R8 halted lo");
        rd(2'd0, 8'hFF, "R8 halted hi");
        wr(2'd0, 8'h00);
        chk_out(0, 1'b0, "R7 new count low");
        tick(0);
        rd(2'd0, 8'h03, "R8 restart lo");
        rd(2'd0, 8'h00, "R8 restart hi");

        // R9 snapshot
        wr(2'd3, 8'h00);
        tick(0);
        rd(2'd0, 8'h03, "R9 snap lo");
        rd(2'd0, 8'h00, "R9 snap hi");
        rd(2'd0, 8'h02, "R9 live lo");
        rd(2'd0, 8'h00, "R9 live hi");
        wr(2'd3, 8'h00);
        tick(0);
        wr(2'd3, 8'h00);
        tick(0);
        rd(2'd0, 8'h02, "R9 second ignored lo");
        rd(2'd0, 8'h00, "R9 second ignored hi");
        rd(2'd0, 8'h00, "R9 live after lo");
        rd(2'd0, 8'h00, "R9 live after hi");
        chk_out(0, 1'b1, "R7 tc after snap");

        // R3 single-byte modes on channel 1
        wr(2'd3, 8'h60);
        wr(2'd1, 8'h34);
        tick(1);
        rd(2'd1, 8'h34, "R3 lo only");
        wr(2'd3, 8'h50);
        wr(2'd1, 8'h12);
        tick(1);
        rd(2'd1, 8'h12, "R3 hi only");
        wr(2'd3, 8'h70);
        rd(2'd1, 8'h00, "R3 hi only cleared lo");
        rd(2'd1, 8'h12, "R3 hi only value");

        // R10 control byte resets write pointer
        wr(2'd1, 8'hAA);
        wr(2'd3, 8'h70);
        wr(2'd1, 8'h07);
        wr(2'd1, 8'h00);
        tick(1);
        rd(2'd1, 8'h07, "R10 pointer reset lo");
        rd(2'd1, 8'h00, "R10 pointer reset hi");

        // R5 BCD on channel 2
        wr(2'd3, 8'hB1);
        wr(2'd2, 8'h00);
        wr(2'd2, 8'h01);
        tick(2);
        tick(2);
        rd(2'd2, 8'h99, "R5 bcd borrow lo");
        rd(2'd2, 8'h00, "R5 bcd borrow hi");
        wr(2'd2, 8'h00);
        wr(2'd2, 8'h00);
        tick(2);
        tick(2);
        rd(2'd2, 8'h99, "R5 bcd wrap lo");
        rd(2'd2, 8'h99, "R5 bcd wrap hi");
        chk_out(2, 1'b0, "R5 bcd wrap out");

        // R2 illegal select ignored
        @(negedge clk);
        saved = tout;
        wr(2'd3, 8'hFA);
        chk_out(0, saved[0], "R2 illegal ch0");
        chk_out(1, saved[1], "R2 illegal ch1");
        chk_out(2, saved[2], "R2 illegal ch2");
        rd(2'd2, 8'h99, "R2 illegal keeps order");

        // R4 other modes drive high, bit 3 don't-care
        wr(2'd3, 8'hBC);
        chk_out(2, 1'b1, "R4 mode x10 top set");
        wr(2'd3, 8'hB0);
        chk_out(2, 1'b0, "R4 back to mode0");
        wr(2'd3, 8'hB4);
        chk_out(2, 1'b1, "R4 mode 010");

        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule